// File: doc/BRIEF.md
# Three-Wire Configuration Port and Register Bank

This block takes write-only configuration words from a host over a three-wire serial link: a serial clock, a data line and a latch enable. It decodes each word into a small bank of configuration registers that drive a stereo converter's settings. These cover the data-interface format, word length and clock polarities, clock-master selection and frame ratio, oversampling choice, high-pass filter bypass, power-down controls, per-channel gain and mute, a global mute, a monitor-output enable and per-channel input selection. The serial inputs are assumed to be already synchronous to the system clock. The block detects their edges by comparing each input with its value one system clock earlier.

A word is 16 bits long. The 7 most significant bits carry the register address and the 9 least significant bits carry the register data. Only a rising edge on the latch enable commits a word, and only if exactly 16 serial-clock rising edges came before it. A gain write can carry a link flag that copies the same gain code into both channels. One address acts as a software reset that restores every field to its power-on value. Each channel's gain code is also presented as a signed decibel value.

The link has no back-pressure: the host paces the words, and each committed word is applied in one cycle. The block has no valid/ready handshake because nothing flows out as a stream, so every output is a plain level.

Top module: `ctl3w_regbank`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock, most significant bit first. After 16 bits, word bits [15:9] are the register address and bits [8:0] are the register data.
- R2: Configuration outputs change only in response to a rising edge of the latch enable. Shifting bits without a latch edge leaves every output unchanged. A committed word is visible on the outputs no later than 3 system clocks after the latch enable is sampled high.
- R3: A latch edge that follows more or fewer than 16 serial-clock rising edges (counted since the previous latch edge or reset) discards the word. The bit counter restarts on every latch edge.
- R4: Reset and power-on values are as follows. Format is 2'b10, word length is 2'b10, frame ratio is 3'b010, ADC disable is 1, input power-down is 1, and both gain codes are 5'b01100. Every other field is 0.
- R5: Address 0x16 sets format from data[1:0], frame polarity from [2], bit-clock polarity from [3], word length from [5:4] and high-pass disable from [8].
- R6: Address 0x17 sets frame ratio from data[2:0], oversampling select from [3] and master mode from [8].
- R7: Address 0x18 sets power-down from data[0] and ADC disable from [1]. Address 0x14 sets the monitor-output enable from data[5].
- R8: Address 0x19 sets left gain from data[4:0], left mute from [5] and global mute from [7]. Address 0x1A sets right gain from data[4:0] and right mute from [5].
- R9: On a write to 0x19 or 0x1A with data[6] set, the gain code is stored into both channels. Only the addressed channel's mute changes.
- R10: Address 0x1B sets left input select from data[2:0], right input select from [6:4] and input power-down from [8].
- R11: Any committed write to address 0x1F restores every field to its R4 value, whatever the data.
- R12: A committed word whose address is not 0x14, 0x16–0x1B or 0x1F leaves every output unchanged.
- R13: Each channel's decibel output is a 6-bit two's-complement value equal to the gain code minus 12. Code 0 gives -12, code 12 gives 0 and code 31 gives +19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk |
| sdat_i | input | 1 | Serial data, MSB first |
| latch_i | input | 1 | Latch enable; rising edge commits the word |
| fmt_o | output | 2 | Data-interface format |
| frm_pol_o | output | 1 | Frame-clock polarity / DSP early-late select |
| bclk_pol_o | output | 1 | Bit-clock polarity |
| wlen_o | output | 2 | Word-length code |
| hpf_off_o | output | 1 | High-pass filter disable |
| ratio_o | output | 3 | Master-mode frame ratio code |
| osr_o | output | 1 | Oversampling select |
| master_o | output | 1 | Clock master mode |
| pdwn_o | output | 1 | Full power-down |
| adc_off_o | output | 1 | Converter disable |
| lgain_o | output | 5 | Left gain code |
| rgain_o | output | 5 | Right gain code |
| ldb_o | output | 6 | Left gain in dB, signed |
| rdb_o | output | 6 | Right gain in dB, signed |
| lmute_o | output | 1 | Left mute |
| rmute_o | output | 1 | Right mute |
| gmute_o | output | 1 | Global mute |
| rec_en_o | output | 1 | Monitor-output enable |
| lsel_o | output | 3 | Left input select |
| rsel_o | output | 3 | Right input select |
| ain_off_o | output | 1 | Input selector power-down |

## Verification
The assertions check the following on every cycle:
- no register changes without a committed word;
- a miscounted word never produces a commit;
- a linked gain write always leaves the two gain codes equal;
- the reset address always restores the defaults;
- an unmapped address never disturbs the bank.

Some behaviour only the bench's scenarios can show:
- the bit order on the wire;
- the exact placement of each field within the data;
- the decibel mapping;
- that mutes are not mirrored by a linked write;
- that a complete word shifted in without a latch edge stays invisible until the edge arrives.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 9;
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int GAIN_W   = 5;
  localparam int SEL_W    = 3;
  localparam int NUM_CH   = 2;
  localparam logic [GAIN_W-1:0] GAIN_DEF = 5'b01100;

  localparam logic [ADDR_W-1:0] A_REC = 7'h14;
  localparam logic [ADDR_W-1:0] A_IFC = 7'h16;
  localparam logic [ADDR_W-1:0] A_CLK = 7'h17;
  localparam logic [ADDR_W-1:0] A_PWR = 7'h18;
  localparam logic [ADDR_W-1:0] A_GL  = 7'h19;
  localparam logic [ADDR_W-1:0] A_GR  = 7'h1A;
  localparam logic [ADDR_W-1:0] A_MUX = 7'h1B;
  localparam logic [ADDR_W-1:0] A_RST = 7'h1F;

  typedef struct packed {
    logic [1:0]        fmt;
    logic              frm_pol;
    logic              bclk_pol;
    logic [1:0]        wlen;
    logic              hpf_off;
    logic [2:0]        ratio;
    logic              osr;
    logic              master;
    logic              pdwn;
    logic              adc_off;
    logic [GAIN_W-1:0] lgain;
    logic              lmute;
    logic [GAIN_W-1:0] rgain;
    logic              rmute;
    logic              gmute;
    logic              rec_en;
    logic [SEL_W-1:0]  lsel;
    logic [SEL_W-1:0]  rsel;
    logic              ain_off;
  } cfg_t;

  function automatic cfg_t cfg_default();
    cfg_t c;
    c         = '0;
    c.fmt     = 2'b10;
    c.wlen    = 2'b10;
    c.ratio   = 3'b010;
    c.adc_off = 1'b1;
    c.lgain   = GAIN_DEF;
    c.rgain   = GAIN_DEF;
    c.ain_off = 1'b1;
    return c;
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a == A_REC) || (a == A_IFC) || (a == A_CLK) || (a == A_PWR) ||
           (a == A_GL)  || (a == A_GR)  || (a == A_MUX) || (a == A_RST);
  endfunction
endpackage

// File: rtl/ctl3w_rx.sv
module ctl3w_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              latch_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              sclk_q, latch_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_rise, latch_rise;

  assign sclk_rise  = sclk_i  & ~sclk_q;
  assign latch_rise = latch_i & ~latch_q;

  // R1: MSB-first shift on serial-clock rise; R3: count saturates past full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      latch_q    <= 1'b0;
      shreg      <= '0;
      cnt        <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      sclk_q     <= sclk_i;
      latch_q    <= latch_i;
      word_vld_o <= 1'b0;
      if (latch_rise) begin
        word_vld_o <= (cnt == CNT_FULL);
        word_o     <= shreg;
        cnt        <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdat_i};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  AST_MISCOUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && cnt != CNT_FULL) |=> !word_vld_o); // R3
  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> !word_vld_o); // R2
endmodule

// File: rtl/ctl3w_store.sv
module ctl3w_store
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_vld_i) begin
      case (wr_addr_i)
        A_IFC: begin  // R5
          cfg_d.fmt      = wr_data_i[1:0];
          cfg_d.frm_pol  = wr_data_i[2];
          cfg_d.bclk_pol = wr_data_i[3];
          cfg_d.wlen     = wr_data_i[5:4];
          cfg_d.hpf_off  = wr_data_i[8];
        end
        A_CLK: begin  // R6
          cfg_d.ratio  = wr_data_i[2:0];
          cfg_d.osr    = wr_data_i[3];
          cfg_d.master = wr_data_i[8];
        end
        A_PWR: begin  // R7
          cfg_d.pdwn    = wr_data_i[0];
          cfg_d.adc_off = wr_data_i[1];
        end
        A_REC: cfg_d.rec_en = wr_data_i[5];
        A_GL: begin   // R8, R9
          cfg_d.lgain = wr_data_i[GAIN_W-1:0];
          cfg_d.lmute = wr_data_i[5];
          cfg_d.gmute = wr_data_i[7];
          if (wr_data_i[6]) cfg_d.rgain = wr_data_i[GAIN_W-1:0];
        end
        A_GR: begin   // R8, R9
          cfg_d.rgain = wr_data_i[GAIN_W-1:0];
          cfg_d.rmute = wr_data_i[5];
          if (wr_data_i[6]) cfg_d.lgain = wr_data_i[GAIN_W-1:0];
        end
        A_MUX: begin  // R10
          cfg_d.lsel    = wr_data_i[SEL_W-1:0];
          cfg_d.rsel    = wr_data_i[SEL_W+3:4];
          cfg_d.ain_off = wr_data_i[8];
        end
        A_RST: cfg_d = cfg_default();  // R11
        default: ;                     // R12
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cfg_default();  // R4
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld_i |=> $stable(cfg_q)); // R2
  AST_LINK_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_i && (wr_addr_i == A_GL || wr_addr_i == A_GR) && wr_data_i[6])
      |=> (cfg_q.lgain == cfg_q.rgain)); // R9
  AST_SWRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_i && wr_addr_i == A_RST) |=> (cfg_q == cfg_default())); // R11
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_i && !is_mapped(wr_addr_i)) |=> $stable(cfg_q)); // R12
endmodule

// File: rtl/ctl3w_gain_db.sv
module ctl3w_gain_db #(
  parameter int GAIN_W    = 5,
  parameter int GAIN_ZERO = 12
) (
  input  logic [GAIN_W-1:0]        code_i,
  output logic signed [GAIN_W:0]   db_o
);
  // R13: linear map, code GAIN_ZERO is 0 dB
  assign db_o = $signed({1'b0, code_i}) - $signed((GAIN_W+1)'(GAIN_ZERO));
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
  import ctl3w_pkg::*;
#(
  parameter int GAIN_ZERO = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk_i,
  input  logic                    sdat_i,
  input  logic                    latch_i,
  output logic [1:0]              fmt_o,
  output logic                    frm_pol_o,
  output logic                    bclk_pol_o,
  output logic [1:0]              wlen_o,
  output logic                    hpf_off_o,
  output logic [2:0]              ratio_o,
  output logic                    osr_o,
  output logic                    master_o,
  output logic                    pdwn_o,
  output logic                    adc_off_o,
  output logic [GAIN_W-1:0]       lgain_o,
  output logic [GAIN_W-1:0]       rgain_o,
  output logic signed [GAIN_W:0]  ldb_o,
  output logic signed [GAIN_W:0]  rdb_o,
  output logic                    lmute_o,
  output logic                    rmute_o,
  output logic                    gmute_o,
  output logic                    rec_en_o,
  output logic [SEL_W-1:0]        lsel_o,
  output logic [SEL_W-1:0]        rsel_o,
  output logic                    ain_off_o
);
  logic              word_vld;
  logic [WORD_W-1:0] word;
  cfg_t              cfg;

  ctl3w_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk_i),
    .sdat_i    (sdat_i),
    .latch_i   (latch_i),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  ctl3w_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vld_i (word_vld),
    .wr_addr_i(word[WORD_W-1:DATA_W]),
    .wr_data_i(word[DATA_W-1:0]),
    .cfg_o    (cfg)
  );

  logic [GAIN_W-1:0]      gcode [NUM_CH];
  logic signed [GAIN_W:0] gdb   [NUM_CH];
  assign gcode[0] = cfg.lgain;
  assign gcode[1] = cfg.rgain;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_db
    ctl3w_gain_db #(.GAIN_W(GAIN_W), .GAIN_ZERO(GAIN_ZERO)) u_db (
      .code_i(gcode[ch]),
      .db_o  (gdb[ch])
    );
  end

  assign fmt_o      = cfg.fmt;
  assign frm_pol_o  = cfg.frm_pol;
  assign bclk_pol_o = cfg.bclk_pol;
  assign wlen_o     = cfg.wlen;
  assign hpf_off_o  = cfg.hpf_off;
  assign ratio_o    = cfg.ratio;
  assign osr_o      = cfg.osr;
  assign master_o   = cfg.master;
  assign pdwn_o     = cfg.pdwn;
  assign adc_off_o  = cfg.adc_off;
  assign lgain_o    = cfg.lgain;
  assign rgain_o    = cfg.rgain;
  assign ldb_o      = gdb[0];
  assign rdb_o      = gdb[1];
  assign lmute_o    = cfg.lmute;
  assign rmute_o    = cfg.rmute;
  assign gmute_o    = cfg.gmute;
  assign rec_en_o   = cfg.rec_en;
  assign lsel_o     = cfg.lsel;
  assign rsel_o     = cfg.rsel;
  assign ain_off_o  = cfg.ain_off;
endmodule

// File: tb/sim_ctl3w_regbank.sv
module sim_ctl3w_regbank;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0, latch = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [1:0] fmt, wlen; logic frm_pol, bclk_pol, hpf_off, osr, master, pdwn, adc_off;
  logic [2:0] ratio, lsel, rsel; logic [4:0] lgain, rgain;
  logic signed [5:0] ldb, rdb;
  logic lmute, rmute, gmute, rec_en, ain_off;

  ctl3w_regbank u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .latch_i(latch),
    .fmt_o(fmt), .frm_pol_o(frm_pol), .bclk_pol_o(bclk_pol), .wlen_o(wlen),
    .hpf_off_o(hpf_off), .ratio_o(ratio), .osr_o(osr), .master_o(master),
    .pdwn_o(pdwn), .adc_off_o(adc_off), .lgain_o(lgain), .rgain_o(rgain),
    .ldb_o(ldb), .rdb_o(rdb), .lmute_o(lmute), .rmute_o(rmute), .gmute_o(gmute),
    .rec_en_o(rec_en), .lsel_o(lsel), .rsel_o(rsel), .ain_off_o(ain_off)
  );

  wire [34:0] obs = {fmt, frm_pol, bclk_pol, wlen, hpf_off, ratio, osr, master,
                     pdwn, adc_off, lgain, lmute, rgain, rmute, gmute, rec_en,
                     lsel, rsel, ain_off};

  // reference model, built from the requirements
  logic [1:0] m_fmt, m_wlen; logic m_fp, m_bp, m_hpf, m_osr, m_ms, m_pd, m_adc;
  logic [2:0] m_ratio, m_lsel, m_rsel; logic [4:0] m_lg, m_rg;
  logic m_lm, m_rm, m_gm, m_rec, m_ain;

  function automatic logic [34:0] m_pack();
    return {m_fmt, m_fp, m_bp, m_wlen, m_hpf, m_ratio, m_osr, m_ms, m_pd, m_adc,
            m_lg, m_lm, m_rg, m_rm, m_gm, m_rec, m_lsel, m_rsel, m_ain};
  endfunction

  task automatic m_defaults();  // R4
    m_fmt = 2'b10; m_wlen = 2'b10; m_ratio = 3'b010; m_adc = 1'b1; m_ain = 1'b1;
    m_lg = 5'b01100; m_rg = 5'b01100;
    m_fp = 0; m_bp = 0; m_hpf = 0; m_osr = 0; m_ms = 0; m_pd = 0;
    m_lm = 0; m_rm = 0; m_gm = 0; m_rec = 0; m_lsel = 0; m_rsel = 0;
  endtask

  task automatic m_apply(input logic [6:0] a, input logic [8:0] d);
    case (a)
      7'h16: begin m_fmt = d[1:0]; m_fp = d[2]; m_bp = d[3]; m_wlen = d[5:4]; m_hpf = d[8]; end
      7'h17: begin m_ratio = d[2:0]; m_osr = d[3]; m_ms = d[8]; end
      7'h18: begin m_pd = d[0]; m_adc = d[1]; end
      7'h14: m_rec = d[5];
      7'h19: begin m_lg = d[4:0]; m_lm = d[5]; m_gm = d[7]; if (d[6]) m_rg = d[4:0]; end
      7'h1A: begin m_rg = d[4:0]; m_rm = d[5]; if (d[6]) m_lg = d[4:0]; end
      7'h1B: begin m_lsel = d[2:0]; m_rsel = d[6:4]; m_ain = d[8]; end
      7'h1F: m_defaults();
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [6:0] a, input logic [8:0] d);
    case (a)
      7'h16: return "R5";
      7'h17: return "R6";
      7'h18, 7'h14: return "R7";
      7'h19, 7'h1A: return d[6] ? "R9" : "R8";
      7'h1B: return "R10";
      7'h1F: return "R11";
      default: return "R12";
    endcase
  endfunction

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_db(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s dB actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_dbs();  // R13
    chk_db("R13 left",  int'(ldb), int'(m_lg) - 12);
    chk_db("R13 right", int'(rdb), int'(m_rg) - 12);
  endtask

  task automatic put_bit(input logic b);
    sdat = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic shift_bits(input logic [16:0] w, input int n);  // R1: MSB first
    latch = 1'b0;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
  endtask

  task automatic pulse_latch();
    latch = 1'b1;
    repeat (4) @(negedge clk);
    latch = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {7'h16, 9'h1BD}, {7'h17, 9'h10D}, {7'h18, 9'h003}, {7'h18, 9'h000},
    {7'h14, 9'h020}, {7'h19, 9'h0BF}, {7'h1A, 9'h005}, {7'h19, 9'h047},
    {7'h1A, 9'h060}, {7'h1B, 9'h175}, {7'h1B, 9'h043}, {7'h05, 9'h1FF},
    {7'h15, 9'h1FF}, {7'h1F, 9'h000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 reset", obs, m_pack());
    chk_dbs();

    // table walk, one word per entry
    for (int v = 0; v < NV; v++) begin
      shift_bits({1'b0, VEC[v]}, 16);
      pulse_latch();
      m_apply(VEC[v][15:9], VEC[v][8:0]);
      chk(tag_of(VEC[v][15:9], VEC[v][8:0]), obs, m_pack());
      chk_dbs();
    end

    // R1: bit order, a non-palindromic ratio/select pattern
    shift_bits({1'b0, 7'h1B, 9'h016}, 16);
    pulse_latch();
    m_apply(7'h1B, 9'h016);
    chk("R1 bit order", obs, m_pack());

    // R2: full word shifted, no latch edge yet -> nothing changes
    shift_bits({1'b0, 7'h17, 9'h104}, 16);
    repeat (6) @(negedge clk);
    chk("R2 no latch", obs, m_pack());
    pulse_latch();
    m_apply(7'h17, 9'h104);
    chk("R2 after latch", obs, m_pack());

    // R3: short word (15 bits) discarded
    shift_bits({2'b0, 15'h3FFF}, 15);
    pulse_latch();
    chk("R3 short word", obs, m_pack());
    // R3: long word (17 bits, last 16 form a valid write) discarded
    shift_bits({1'b1, 7'h18, 9'h003}, 17);
    pulse_latch();
    chk("R3 long word", obs, m_pack());
    // R3: counter restarts, next good word lands
    shift_bits({1'b0, 7'h18, 9'h001}, 16);
    pulse_latch();
    m_apply(7'h18, 9'h001);
    chk("R3 recover", obs, m_pack());

    // R13 extremes via linked writes: code 0 and code 31
    shift_bits({1'b0, 7'h19, 9'h040}, 16);
    pulse_latch();
    m_apply(7'h19, 9'h040);
    chk_db("R13 code0", int'(ldb), -12);
    shift_bits({1'b0, 7'h1A, 9'h05F}, 16);
    pulse_latch();
    m_apply(7'h1A, 9'h05F);
    chk_db("R13 code31", int'(rdb), 19);
    chk("R9 linked max", obs, m_pack());

    // R11 with nonzero data
    shift_bits({1'b0, 7'h1F, 9'h1FF}, 16);
    pulse_latch();
    m_apply(7'h1F, 9'h1FF);
    chk("R11 reset with data", obs, m_pack());
    chk_db("R13 default", int'(ldb), 0);

    // R4: hardware reset mid-configuration
    shift_bits({1'b0, 7'h16, 9'h1FF}, 16);
    pulse_latch();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_defaults();
    @(negedge clk);
    chk("R4 re-reset", obs, m_pack());

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule